// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs one clause 22 management transaction at a time on a two-wire serial management bus. The host side presents an operation (read or write), a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. It then pulses `start_i`. The block divides its system clock down to a management clock (MDC) at one of three rates. It shifts out the frame and releases the data line during the read turnaround. It reports completion with a single-cycle `done_o`, together with the read data and a read-error flag.

The data line is driven through an output value and a separate output enable, so the pad can be tri-stated. The block also tracks whether the PHY tolerates frames without the 32-bit preamble. A clean read of the status register (register 1) with bit 6 set turns preamble suppression on. A read error, a pulse on `phy_detach_i` or a reset turns it off again.

Top module: `mdio_master`

## Requirements
- R1: A frame is a 65-bit sequence, sent most significant bit first: 32 preamble ones (omitted while suppression is on), start bits 0 then 1, opcode 1,0 for a read or 0,1 for a write, the 5-bit PHY address, the 5-bit register address, 2 turnaround bits, 16 data bits, and 1 idle bit with the line released.
- R2: On a write, the turnaround is driven as 1 then 0, followed by the 16 write-data bits with the enable asserted. The idle bit is released.
- R3: On a read, the enable is deasserted from the first turnaround bit to the end of the frame. The 16 data bits are sampled on MDC rising edges, MSB first, and returned on `rdata_o`.
- R4: On a read, if the line sampled in the second turnaround bit is not 0, `rd_err_o` is 1 when `done_o` pulses. Otherwise it is 0, and it is always 0 after a write.
- R5: Whenever `busy_o` is low, `mdc_o` and `mdio_oe_o` are both 0.
- R6: `rate_i` is captured at start. Code 01 gives MDC half-periods of `DIV_MID` system cycles and code 10 gives `DIV_FAST`. Codes 00 and 11 give `DIV_SLOW`, which is the default, slowest rate.
- R7: After a read of register 1 that completes without error and returns bit 6 set, later frames omit the preamble and are 33 bits long.
- R8: Preamble suppression is cancelled by any read error, by a `phy_detach_i` pulse, or by reset, so the next frame again carries the preamble.
- R9: `busy_o` rises the cycle after an accepted start and stays high for the whole frame. A start pulse while busy is ignored and does not change the frame in flight.
- R10: A start with PHY address 1Fh is refused. No frame begins, and `busy_o` and `done_o` stay low.
- R11: `done_o` is a one-cycle pulse in the cycle `busy_o` falls, after the idle bit's MDC high phase. `mdc_o` is 0 in that cycle.
- R12: The line (`mdio_o`, `mdio_oe_o`) changes only while MDC is low, so it is stable during each MDC high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, one cycle |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Write data |
| rate_i | input | 2 | MDC rate code |
| phy_detach_i | input | 1 | Pulse when the PHY is disconnected |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Frame complete, one cycle |
| rd_err_o | output | 1 | Turnaround not answered on the last read |
| rdata_o | output | 16 | Read data |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench builds the block with half-period divisors of 4, 2 and 1 system cycles. Every rate code, including the single-cycle half-period corner, then finishes a full 65-bit frame in a few hundred cycles. That is short enough for dozens of random reads and writes, mixed with directed runs that switch preamble suppression on and off through status reads, injected turnaround errors, detach pulses and a mid-run reset.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PRE_LEN    = 32;
    localparam int FRAME_LEN  = 64;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int POS_W      = $clog2(FRAME_LEN + 1);
    localparam int IDX_W      = $clog2(FRAME_LEN);
    // bit positions inside the full (preambled) frame
    localparam int TA1_POS    = 46;
    localparam int TA2_POS    = 47;
    localparam int DATA_POS   = 48;
    localparam int IDLE_POS   = 64;
    localparam logic [ADDR_W-1:0] RSVD_PHY   = 5'h1F;
    localparam logic [ADDR_W-1:0] STATUS_REG = 5'd1;
    localparam int SUPP_BIT   = 6;

    typedef enum logic [1:0] {
        RATE_SLOW = 2'b00,
        RATE_MID  = 2'b01,
        RATE_FAST = 2'b10,
        RATE_ALT  = 2'b11
    } rate_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
#(
    parameter int DIV_SLOW = 20,
    parameter int DIV_MID  = 10,
    parameter int DIV_FAST = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [1:0] rate_i,
    output logic       tick_o
);
    localparam int DMAX_A = (DIV_SLOW > DIV_MID) ? DIV_SLOW : DIV_MID;
    localparam int DMAX   = (DMAX_A > DIV_FAST) ? DMAX_A : DIV_FAST;
    localparam int CW     = $clog2(DMAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] half;
    } gen_t;

    gen_t          q, d;
    logic [CW-1:0] half_sel;

    always_comb begin
        case (rate_e'(rate_i))
            RATE_MID:  half_sel = CW'(DIV_MID);
            RATE_FAST: half_sel = CW'(DIV_FAST);
            default:   half_sel = CW'(DIV_SLOW);
        endcase
    end

    assign tick_o = run_i && (q.cnt == q.half - 1'b1);

    always_comb begin
        d = q;
        if (!run_i) begin
            d.cnt  = '0;
            d.half = half_sel;
        end else if (tick_o) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt  <= '0;
            q.half <= CW'(DIV_SLOW);
        end else begin
            q <= d;
        end
    end

    // R6
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (q.cnt < q.half));
    // R6
    half_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i)) |-> $stable(q.half));
endmodule

// File: rtl/mdio_presup.sv
module mdio_presup
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic              err_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] reg_i,
    input  logic              cap_bit_i,
    input  logic              detach_i,
    output logic              sup_o
);
    typedef struct packed {
        logic sup;
    } sup_t;

    sup_t q, d;

    always_comb begin
        d = q;
        if (detach_i) begin
            d.sup = 1'b0;
        end else if (done_i && rd_i) begin
            if (err_i)
                d.sup = 1'b0;
            else if (reg_i == STATUS_REG && cap_bit_i)
                d.sup = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sup_o = q.sup;

    // R8
    detach_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        detach_i |=> !sup_o);
    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && rd_i && err_i) |=> !sup_o);
    // R7
    sup_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sup_o) |-> $past(done_i && rd_i && !err_i && reg_i == STATUS_REG && cap_bit_i));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] phy_i,
    input  logic [ADDR_W-1:0] reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              sup_i,
    input  logic              tick_i,
    input  logic              mdio_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    output logic              last_rd_o,
    output logic [ADDR_W-1:0] last_reg_o
);
    typedef struct packed {
        logic                 busy;
        logic                 phase;   // 0: MDC low half, 1: MDC high half
        logic [POS_W-1:0]     pos;
        logic [FRAME_LEN-1:0] sh;
        logic [FRAME_LEN-1:0] oe;
        logic                 is_rd;
        logic [ADDR_W-1:0]    regad;
        logic [DATA_W-1:0]    rdata;
        logic                 err;
        logic                 done;
    } frm_t;

    frm_t             q, d;
    logic             accept;
    logic             in_frame;
    logic [IDX_W-1:0] idx;

    assign accept   = !q.busy && start_i && (phy_i != RSVD_PHY);
    assign in_frame = q.pos < POS_W'(FRAME_LEN);
    assign idx      = IDX_W'(FRAME_LEN - 1) - q.pos[IDX_W-1:0];

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (accept) begin
            d.busy  = 1'b1;
            d.phase = 1'b0;
            d.pos   = sup_i ? POS_W'(PRE_LEN) : '0;
            d.sh    = {{PRE_LEN{1'b1}}, 2'b01, (rd_i ? 2'b10 : 2'b01), phy_i, reg_i,
                       (rd_i ? 2'b11 : 2'b10), (rd_i ? {DATA_W{1'b0}} : wdata_i)};
            d.oe    = rd_i ? {{TA1_POS{1'b1}}, {(FRAME_LEN - TA1_POS){1'b0}}}
                           : {FRAME_LEN{1'b1}};
            d.is_rd = rd_i;
            d.regad = reg_i;
            d.err   = 1'b0;
        end else if (q.busy && tick_i) begin
            if (!q.phase) begin
                d.phase = 1'b1;
                if (q.is_rd && q.pos == POS_W'(TA2_POS))
                    d.err = (mdio_i != 1'b0);
                if (q.is_rd && q.pos >= POS_W'(DATA_POS) && in_frame)
                    d.rdata = {q.rdata[DATA_W-2:0], mdio_i};
            end else begin
                d.phase = 1'b0;
                if (q.pos == POS_W'(IDLE_POS)) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.pos = q.pos + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o     = q.busy;
    assign done_o     = q.done;
    assign err_o      = q.err;
    assign rdata_o    = q.rdata;
    assign mdc_o      = q.busy && q.phase;
    assign mdio_o     = q.busy && in_frame && q.sh[idx];
    assign mdio_oe_o  = q.busy && in_frame && q.oe[idx];
    assign last_rd_o  = q.is_rd;
    assign last_reg_o = q.regad;

    // R12
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));
    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && start_i) |=> ($stable(q.is_rd) && $stable(q.regad)));
    // R10
    rsvd_phy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && start_i && phy_i == RSVD_PHY) |=> !busy_o);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !mdc_o && $past(busy_o)));
    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R3
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.is_rd && q.pos >= POS_W'(TA1_POS)) |-> !mdio_oe_o);
    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mdc_o && !mdio_oe_o));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_SLOW = 20,
    parameter int DIV_MID  = 10,
    parameter int DIV_FAST = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        rd_i,
    input  logic [4:0]  phy_addr_i,
    input  logic [4:0]  reg_addr_i,
    input  logic [15:0] wdata_i,
    input  logic [1:0]  rate_i,
    input  logic        phy_detach_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        rd_err_o,
    output logic [15:0] rdata_o,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe_o,
    input  logic        mdio_i
);
    logic              tick;
    logic              sup;
    logic              last_rd;
    logic [ADDR_W-1:0] last_reg;

    mdio_clkgen #(
        .DIV_SLOW (DIV_SLOW),
        .DIV_MID  (DIV_MID),
        .DIV_FAST (DIV_FAST)
    ) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_o),
        .rate_i (rate_i),
        .tick_o (tick)
    );

    mdio_frame u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .rd_i       (rd_i),
        .phy_i      (phy_addr_i),
        .reg_i      (reg_addr_i),
        .wdata_i    (wdata_i),
        .sup_i      (sup),
        .tick_i     (tick),
        .mdio_i     (mdio_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (rd_err_o),
        .rdata_o    (rdata_o),
        .mdc_o      (mdc_o),
        .mdio_o     (mdio_o),
        .mdio_oe_o  (mdio_oe_o),
        .last_rd_o  (last_rd),
        .last_reg_o (last_reg)
    );

    mdio_presup u_presup (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (done_o),
        .err_i     (rd_err_o),
        .rd_i      (last_rd),
        .reg_i     (last_reg),
        .cap_bit_i (rdata_o[SUPP_BIT]),
        .detach_i  (phy_detach_i),
        .sup_o     (sup)
    );
endmodule

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
    localparam int DS = 4;
    localparam int DM = 2;
    localparam int DF = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [4:0]  phy_addr_i = '0;
    logic [4:0]  reg_addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [1:0]  rate_i = '0;
    logic        phy_detach_i = 1'b0;
    logic        mdio_i = 1'b1;
    logic        busy_o, done_o, rd_err_o, mdc_o, mdio_o, mdio_oe_o;
    logic [15:0] rdata_o;

    always #4 clk = ~clk;

    mdio_master #(.DIV_SLOW(DS), .DIV_MID(DM), .DIV_FAST(DF)) i_mdio_master (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
        .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
        .rate_i(rate_i), .phy_detach_i(phy_detach_i), .busy_o(busy_o),
        .done_o(done_o), .rd_err_o(rd_err_o), .rdata_o(rdata_o), .mdc_o(mdc_o),
        .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
    );

    int   vectors = 0;
    int   fails = 0;
    bit   done_flag = 0;
    logic resp   [0:64];
    logic cap_o  [0:64];
    logic cap_oe [0:64];
    int   pos = 0, rises = 0, hi_cnt = 0, hi_len = 0, idle_bad = 0;
    logic prev_mdc = 1'b0;
    bit   model_sup = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int half_of(input logic [1:0] rt);
        case (rt)
            2'b01:   return DM;
            2'b10:   return DF;
            default: return DS;
        endcase
    endfunction

    function automatic logic [63:0] exp_line(input bit rd, input logic [4:0] phy,
                                             input logic [4:0] rg, input logic [15:0] wd);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
                (rd ? 2'b11 : 2'b10), (rd ? 16'h0 : wd)};
    endfunction

    function automatic logic [63:0] exp_en(input bit rd);
        return rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
    endfunction

    // line monitor and PHY model
    always @(negedge clk) begin
        if (!busy_o && (mdc_o || mdio_oe_o)) idle_bad++;
        if (mdc_o && !prev_mdc) begin
            if (pos <= 64) begin
                cap_o[pos]  = mdio_o;
                cap_oe[pos] = mdio_oe_o;
            end
            rises++;
            hi_cnt = 1;
        end else if (mdc_o) begin
            hi_cnt++;
        end
        if (!mdc_o && prev_mdc) begin
            hi_len = hi_cnt;
            pos++;
            mdio_i = (pos <= 64) ? resp[pos] : 1'b1;
        end
        prev_mdc = mdc_o;
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    task automatic run(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, input logic [15:0] rdv, input bit inj,
                       input logic [1:0] rt, input bit poke);
        int base, guard, bad_a;
        bit ok_hdr, ok_tail, stayed;
        logic [63:0] el, ee;
        @(negedge clk);
        rd_i = rd; phy_addr_i = phy; reg_addr_i = rg; wdata_i = wd; rate_i = rt;
        base = model_sup ? 32 : 0;
        for (int i = 0; i <= 64; i++) resp[i] = 1'b1;
        if (rd) begin
            resp[47] = inj;
            for (int k = 0; k < 16; k++) resp[48 + k] = rdv[15 - k];
        end
        pos = base; rises = 0; mdio_i = resp[base];
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R9", "busy after start", busy_o, 1);
        guard = 0;
        while (!done_o && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (poke && guard == 30) begin
                chk(busy_o == 1'b1, "R9", "busy mid frame", busy_o, 1);
                start_i = 1'b1; rd_i = ~rd; reg_addr_i = ~rg; wdata_i = ~wd;
            end
            if (poke && guard == 31) start_i = 1'b0;
        end
        chk(done_o == 1'b1, "R11", "done pulse seen", done_o, 1);
        chk(!busy_o && !mdc_o, "R11", "busy/mdc low at done", {busy_o, mdc_o}, 0);
        chk(rises == 65 - base, model_sup ? "R7" : "R1", "MDC rising edges", rises, 65 - base);
        el = exp_line(rd, phy, rg, wd);
        ee = exp_en(rd);
        ok_hdr = 1; ok_tail = 1; bad_a = -1;
        for (int a = base; a < 64; a++) begin
            if (cap_oe[a] !== ee[63 - a] || (ee[63 - a] && cap_o[a] !== el[63 - a])) begin
                if (a < 46) ok_hdr = 0; else ok_tail = 0;
                if (bad_a < 0) bad_a = a;
            end
        end
        if (cap_oe[64] !== 1'b0) begin
            ok_tail = 0;
            if (bad_a < 0) bad_a = 64;
        end
        chk(ok_hdr, "R1", "header bits, first bad position", bad_a, -1);
        chk(ok_tail, rd ? "R3" : "R2", "turnaround/data/idle bits, first bad position", bad_a, -1);
        chk(hi_len == half_of(rt), "R6", "MDC high half-period", hi_len, half_of(rt));
        if (rd) begin
            chk(rd_err_o == inj, "R4", "read error flag at done", rd_err_o, inj);
            if (!inj) chk(rdata_o == rdv, "R3", "read data", rdata_o, rdv);
        end else begin
            chk(rd_err_o == 1'b0, "R4", "error flag after write", rd_err_o, 0);
        end
        @(negedge clk);
        chk(done_o == 1'b0, "R11", "done lasts one cycle", done_o, 0);
        if (poke) begin
            stayed = 1;
            repeat (40) begin
                @(negedge clk);
                if (busy_o || done_o) stayed = 0;
            end
            chk(stayed, "R9", "ignored start launched nothing", stayed, 1);
        end
        if (rd && inj) model_sup = 0;
        else if (rd && rg == 5'd1 && rdv[6]) model_sup = 1;
    endtask

    task automatic detach();
        @(negedge clk); phy_detach_i = 1'b1;
        @(negedge clk); phy_detach_i = 1'b0;
        model_sup = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        vectors++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit quiet;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy_o, done_o, rd_err_o, mdc_o, mdio_oe_o} == 5'b0, "R5",
            "reset state", {busy_o, done_o, rd_err_o, mdc_o, mdio_oe_o}, 0);

        // directed: every rate, write and reads
        run(0, 5'h03, 5'h00, 16'hA5C3, 16'h0, 0, 2'b00, 0);
        run(1, 5'h0A, 5'h02, 16'h0, 16'h8001, 0, 2'b10, 0);
        run(1, 5'h11, 5'h1E, 16'h0, 16'h7FFE, 0, 2'b01, 0);
        run(0, 5'h1E, 5'h1F, 16'hFFFF, 16'h0, 0, 2'b11, 0);
        // R4: PHY does not answer the turnaround
        run(1, 5'h04, 5'h05, 16'h0, 16'h1234, 1, 2'b10, 0);
        // R7: status read enables suppression, then R8 via read error
        run(1, 5'h01, 5'h01, 16'h0, 16'h0040, 0, 2'b10, 0);
        run(0, 5'h01, 5'h09, 16'h0F0F, 16'h0, 0, 2'b01, 0);
        run(1, 5'h01, 5'h03, 16'h0, 16'hBEEF, 1, 2'b10, 0);
        run(0, 5'h01, 5'h09, 16'h3C3C, 16'h0, 0, 2'b10, 0);
        // R8: detach
        run(1, 5'h02, 5'h01, 16'h0, 16'hFFFF, 0, 2'b10, 0);
        detach();
        run(0, 5'h02, 5'h04, 16'h1111, 16'h0, 0, 2'b10, 0);
        // R8: reset
        run(1, 5'h02, 5'h01, 16'h0, 16'h0041, 0, 2'b10, 0);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        model_sup = 0;
        run(1, 5'h02, 5'h07, 16'h0, 16'h5555, 0, 2'b10, 0);
        // R9: start while busy
        run(0, 5'h06, 5'h0C, 16'hC0DE, 16'h0, 0, 2'b00, 1);
        // R10: reserved PHY address
        @(negedge clk); phy_addr_i = 5'h1F; rd_i = 1'b1; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        quiet = 1;
        repeat (40) begin
            if (busy_o || done_o || mdc_o || mdio_oe_o) quiet = 0;
            @(negedge clk);
        end
        chk(quiet, "R10", "reserved PHY address refused", quiet, 1);

        // constrained random mix
        for (int n = 0; n < 40; n++) begin
            bit          r_rd, r_inj;
            logic [4:0]  r_phy, r_reg;
            logic [15:0] r_wd, r_rdv;
            logic [1:0]  r_rt;
            r_rd  = $urandom_range(0, 1);
            r_phy = 5'($urandom_range(0, 30));
            r_reg = ($urandom_range(0, 3) == 0) ? 5'd1 : 5'($urandom);
            r_wd  = 16'($urandom);
            r_rdv = 16'($urandom);
            r_inj = ($urandom_range(0, 7) == 0);
            r_rt  = 2'($urandom);
            if ($urandom_range(0, 9) == 0) detach();
            run(r_rd, r_phy, r_reg, r_wd, r_rdv, r_inj, r_rt, 0);
        end

        chk(idle_bad == 0, "R5", "MDC/enable active while idle", idle_bad, 0);
        finish_run();
    end
endmodule